// File: doc/BRIEF.md
# Three-Phase PWM Timer with Guarded Carrier Switching

This block generates a symmetric up/down triangular carrier and three gate-enable outputs, one per inverter phase. Each enable is high while the phase's latched duty word is greater than the carrier. The carrier can run at one of three rates in a 4:2:1 ratio. The fastest setting uses a half-period of `BASE_PERIOD` counts, and the slower two use twice and four times that count.

A request to change the rate is not applied directly to the counter. The request must first hold steady for a dwell time. Once it is accepted, the block runs a fixed sequence:

1. Every gate is forced low.
2. At the next valley, the period, rate code and update divider are loaded together, and a one-cycle notification is raised so that downstream scaling can follow.
3. The gates stay low for one full period of the new carrier, then they resume.

The duty words held in the block are shifted at the reload so that the modulation depth is kept.

An update strobe fires at carrier valleys, once every `UPDATE_DIV` valleys. It triggers sampling and the control step, and it latches new duty words.

Top module: `pwmc_top`

## Requirements
- R1: The carrier counts 0,1,...,per,per-1,...,1,0,1,... in steps of one, with no other values. The half-period is per = BASE_PERIOD << activeMode. Rate code 0 is the fastest (per = BASE_PERIOD), code 1 doubles per, and code 2 quadruples it. `activePeriod` always reports the per in use.
- R2: While outputs are enabled, gate bit 0 (phase U), bit 1 (phase V) and bit 2 (phase W) are each high exactly when the corresponding latched duty is greater than the current carrier value.
- R3: `updStb` is high only in valley cycles (carrier 0). Duty inputs are latched at the clock edge that ends a strobe cycle. Consecutive strobes are `UPDATE_DIV` valleys apart. After a reload, the first strobe comes `UPDATE_DIV`+1 valleys after the reload valley, and the reload valley itself never strobes.
- R4: A request on `freqReq` is accepted only after it has held the same value for `DWELL_CYCLES` consecutive cycles. Every change of the request restarts that wait. Code 3 means hold, and a code equal to the active rate is a no-op. Neither of these ever starts a change.
- R5: From the cycle after acceptance, `busy` is high and all three gates are low, until re-enable.
- R6: The new period and rate code take effect only at a valley. `cfgStb` pulses for exactly one cycle, in the cycle after that valley (carrier 1), and `activePeriod`/`activeMode` already show the new setting in that cycle. `activeMode` changes only together with `cfgStb`.
- R7: Counting from the `cfgStb` cycle, `busy` falls and the gates are re-enabled after exactly 2*per cycles of the new carrier, at the edge that ends its next valley.
- R8: While `busy` is high, changes on `freqReq` are ignored. The sequence completes with the rate that was accepted.
- R9: At the reload, each latched duty is shifted left by (new code - old code) when the carrier slows down, or shifted right by (old code - new code) when it speeds up.
- R10: During reset, the carrier is 0, the gates are low, `busy` and `cfgStb` are low, `activeMode` is 0 and `activePeriod` equals BASE_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freqReq | input | 2 | Requested rate code: 0 fast, 1 half, 2 quarter, 3 hold |
| dutyU | input | CNT_W | Duty word for phase U |
| dutyV | input | CNT_W | Duty word for phase V |
| dutyW | input | CNT_W | Duty word for phase W |
| gate | output | 3 | Gate enables: bit 0 U, bit 1 V, bit 2 W |
| carrier | output | CNT_W | Current triangular carrier value |
| updStb | output | 1 | Sampling / control update strobe at valleys |
| cfgStb | output | 1 | One-cycle notification that a new period is in force |
| activePeriod | output | CNT_W | Half-period of the carrier in use |
| activeMode | output | 2 | Rate code in use |
| busy | output | 1 | Change sequence in progress; gates held low |

## Verification
The hardest situation to reach is a request that looks almost valid. Such a request toggles between two legal rates just under the dwell time, or it shows up while a change is already in flight. The stimulus alternates two codes at runs four cycles shorter than the dwell time, holds the hold code well past the dwell time, and changes the request on the first cycle `busy` is seen. Only then does it move on to randomized request codes and hold lengths mixed with random duty words. Throughout, the gates are compared against duties tracked from the strobes, including the shifted copies that are active between the reload and the next strobe.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int NUM_PHASES = 3;
  localparam logic [1:0] MODE_HOLD = 2'd3;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_BLANK = 2'd2
  } seq_state_e;

  // Strobes from the sequencer to the carrier/compare datapath
  typedef struct packed {
    logic       reload;   // load period, rate code, divider; rescale duties
    logic [1:0] newMode;  // rate code to load on reload
    logic       outEn;    // gate outputs permitted
  } seq_ctl_t;

endpackage

// File: rtl/pwmc_seqctl.sv
module pwmc_seqctl
  import pwmc_pkg::*;
#(
  parameter int DWELL_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] freqReq,
  input  logic       valley,
  input  logic [1:0] activeMode,
  output seq_ctl_t   ctl,
  output logic       busy
);

  localparam int DW_W = (DWELL_CYCLES < 2) ? 1 : $clog2(DWELL_CYCLES + 1);
  localparam logic [DW_W-1:0] DWELL_LAST = DW_W'(DWELL_CYCLES - 1);

  seq_state_e      state;
  logic [1:0]      reqPrev;
  logic [1:0]      target;
  logic [DW_W-1:0] dwellCnt;
  logic            outEnQ;
  logic            reqIsChange;

  // A request qualifies only if stable, not the hold code and not the active rate
  assign reqIsChange = (freqReq == reqPrev) && (freqReq != MODE_HOLD) &&
                       (freqReq != activeMode);

  always_comb begin
    ctl.reload  = (state == SEQ_DRAIN) && valley;
    ctl.newMode = target;
    ctl.outEn   = outEnQ;
  end

  assign busy = (state != SEQ_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_RUN;
      reqPrev  <= 2'd0;
      target   <= 2'd0;
      dwellCnt <= '0;
      outEnQ   <= 1'b1;
    end else begin
      reqPrev <= freqReq;
      unique case (state)
        SEQ_RUN: begin
          if (!reqIsChange) begin
            dwellCnt <= '0;
          end else if (dwellCnt == DWELL_LAST) begin
            state    <= SEQ_DRAIN;
            target   <= freqReq;
            outEnQ   <= 1'b0;
            dwellCnt <= '0;
          end else begin
            dwellCnt <= dwellCnt + DW_W'(1);
          end
        end
        SEQ_DRAIN: begin
          dwellCnt <= '0;
          if (valley) state <= SEQ_BLANK;
        end
        SEQ_BLANK: begin
          dwellCnt <= '0;
          if (valley) begin
            state  <= SEQ_RUN;
            outEnQ <= 1'b1;
          end
        end
        default: begin
          state    <= SEQ_RUN;
          outEnQ   <= 1'b1;
          dwellCnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pwmc_datapath.sv
module pwmc_datapath
  import pwmc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BASE_PERIOD = 1000,
  parameter int UPDATE_DIV  = 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  seq_ctl_t                             ctl,
  input  logic [NUM_PHASES-1:0][CNT_W-1:0]     dutyIn,
  output logic                                 valley,
  output logic [CNT_W-1:0]                     carrier,
  output logic                                 updStb,
  output logic                                 cfgStb,
  output logic [NUM_PHASES-1:0]                gate,
  output logic [CNT_W-1:0]                     activePeriod,
  output logic [1:0]                           activeMode
);

  localparam int REP_W = $clog2(UPDATE_DIV + 1);
  localparam logic [CNT_W-1:0] BASE_P   = CNT_W'(BASE_PERIOD);
  localparam logic [REP_W-1:0] REP_FULL = REP_W'(UPDATE_DIV);
  localparam logic [REP_W-1:0] REP_NEXT = REP_W'(UPDATE_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] perReg;
  logic [1:0]       modeReg;
  logic             countUp;
  logic [REP_W-1:0] repCnt;
  logic             cfgQ;

  function automatic logic [CNT_W-1:0] rescale(input logic [CNT_W-1:0] d,
                                               input logic [1:0] fromMode,
                                               input logic [1:0] toMode);
    if (toMode >= fromMode) return d << (toMode - fromMode);
    else                    return d >> (fromMode - toMode);
  endfunction

  assign valley       = (cnt == '0);
  assign carrier      = cnt;
  assign activePeriod = perReg;
  assign activeMode   = modeReg;
  assign cfgStb       = cfgQ;
  assign updStb       = valley && !ctl.reload && (repCnt == '0);

  // Triangular up/down carrier
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else if (countUp) begin
      if (cnt >= perReg) begin
        countUp <= 1'b0;
        cnt     <= cnt - CNT_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else begin
      if (cnt == '0) begin
        countUp <= 1'b1;
        cnt     <= cnt + CNT_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // Period, rate code and repetition divider, reloaded as one step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg  <= BASE_P;
      modeReg <= 2'd0;
      repCnt  <= '0;
      cfgQ    <= 1'b0;
    end else begin
      cfgQ <= ctl.reload;
      if (ctl.reload) begin
        perReg  <= BASE_P << ctl.newMode;
        modeReg <= ctl.newMode;
        repCnt  <= REP_FULL;
      end else if (valley) begin
        if (repCnt == '0) repCnt <= REP_NEXT;
        else              repCnt <= repCnt - REP_W'(1);
      end
    end
  end

  // Per-phase duty latch and compare
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    logic [CNT_W-1:0] dutyQ;
    always_ff @(posedge clk) begin
      if (!rstN)              dutyQ <= '0;
      else if (ctl.reload)    dutyQ <= rescale(dutyQ, modeReg, ctl.newMode);
      else if (updStb)        dutyQ <= dutyIn[i];
    end
    assign gate[i] = ctl.outEn && (dutyQ > cnt);
  end

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int BASE_PERIOD  = 1000,
  parameter int DWELL_CYCLES = 4096,
  parameter int UPDATE_DIV   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       freqReq,
  input  logic [CNT_W-1:0] dutyU,
  input  logic [CNT_W-1:0] dutyV,
  input  logic [CNT_W-1:0] dutyW,
  output logic [2:0]       gate,
  output logic [CNT_W-1:0] carrier,
  output logic             updStb,
  output logic             cfgStb,
  output logic [CNT_W-1:0] activePeriod,
  output logic [1:0]       activeMode,
  output logic             busy
);

  seq_ctl_t                         ctl;
  logic                             valley;
  logic [NUM_PHASES-1:0][CNT_W-1:0] dutyBus;

  assign dutyBus = {dutyW, dutyV, dutyU};

  pwmc_seqctl #(
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .freqReq   (freqReq),
    .valley    (valley),
    .activeMode(activeMode),
    .ctl       (ctl),
    .busy      (busy)
  );

  pwmc_datapath #(
    .CNT_W      (CNT_W),
    .BASE_PERIOD(BASE_PERIOD),
    .UPDATE_DIV (UPDATE_DIV)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .dutyIn      (dutyBus),
    .valley      (valley),
    .carrier     (carrier),
    .updStb      (updStb),
    .cfgStb      (cfgStb),
    .gate        (gate),
    .activePeriod(activePeriod),
    .activeMode  (activeMode)
  );

endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker #(
  parameter int CNT_W       = 16,
  parameter int BASE_PERIOD = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       gate,
  input logic [CNT_W-1:0] carrier,
  input logic             updStb,
  input logic             cfgStb,
  input logic [CNT_W-1:0] activePeriod,
  input logic [1:0]       activeMode,
  input logic             busy
);

  AST_CARRIER_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (carrier != $past(carrier))); // R1

  AST_CARRIER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    carrier <= activePeriod); // R1

  AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    activePeriod == (CNT_W'(BASE_PERIOD) << activeMode)); // R1

  AST_UPD_AT_VALLEY: assert property (@(posedge clk) disable iff (!rstN)
    updStb |-> (carrier == '0)); // R3

  AST_GATES_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (gate == 3'b000)); // R5

  AST_RELOAD_AT_VALLEY: assert property (@(posedge clk) disable iff (!rstN)
    cfgStb |-> (($past(carrier) == '0) && (carrier == CNT_W'(1)) && busy)); // R6

  AST_MODE_ONLY_ON_CFG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeMode) |-> cfgStb); // R6

  AST_CFG_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgStb |=> !cfgStb); // R6

  AST_REENABLE_AT_VALLEY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(carrier) == '0)); // R7

endmodule

bind pwmc_top pwmc_checker #(
  .CNT_W      (CNT_W),
  .BASE_PERIOD(BASE_PERIOD)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .gate        (gate),
  .carrier     (carrier),
  .updStb      (updStb),
  .cfgStb      (cfgStb),
  .activePeriod(activePeriod),
  .activeMode  (activeMode),
  .busy        (busy)
);

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int P   = 6;
  localparam int DW  = 24;
  localparam int DIV = 2;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   freqReq;
  logic [W-1:0] dutyU, dutyV, dutyW;
  logic [2:0]   gate;
  logic [W-1:0] carrier;
  logic         updStb, cfgStb, busy;
  logic [W-1:0] activePeriod;
  logic [1:0]   activeMode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmc_top #(
    .CNT_W(W), .BASE_PERIOD(P), .DWELL_CYCLES(DW), .UPDATE_DIV(DIV)
  ) dut (
    .clk(clk), .rstN(rstN), .freqReq(freqReq),
    .dutyU(dutyU), .dutyV(dutyV), .dutyW(dutyW),
    .gate(gate), .carrier(carrier), .updStb(updStb), .cfgStb(cfgStb),
    .activePeriod(activePeriod), .activeMode(activeMode), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // ---------------- monitor state ----------------
  bit           monOn = 0;
  logic [W-1:0] expDuty [3];
  logic [W-1:0] pendVal [3];
  bit           pendLoad = 0;
  int           prevCarrier = 0;
  bit           prevValid = 0;
  bit           prevUp = 1;
  logic [1:0]   prevMode = 2'd0;
  int           vcount = 0;
  bit           postReload = 0;
  bit           sawFirst = 0;
  bit           inBlank = 0;
  int           blankCnt = 0;
  bit           guardOn = 0;
  bit           busySeen = 0;
  bit           checkTarget = 0;
  logic [1:0]   expTarget = 2'd0;
  bit           randDuty = 0;

  initial begin
    for (int i = 0; i < 3; i++) expDuty[i] = '0;
  end

  always @(negedge clk) begin
    if (monOn) begin
      if (pendLoad) begin
        for (int i = 0; i < 3; i++) expDuty[i] = pendVal[i];
        pendLoad = 0;
      end
      if (guardOn && busy) busySeen = 1;
      if (cfgStb) begin
        check(carrier == W'(1), "R6 carrier at notification", carrier, 1);
        check(activePeriod == (W'(P) << activeMode), "R6 reported period",
              activePeriod, P << activeMode);
        if (checkTarget)
          check(activeMode == expTarget, "R8 accepted rate kept", activeMode, expTarget);
        for (int i = 0; i < 3; i++) begin
          if (activeMode >= prevMode) expDuty[i] = expDuty[i] << (activeMode - prevMode);
          else                        expDuty[i] = expDuty[i] >> (prevMode - activeMode);
        end
        prevMode   = activeMode;
        vcount     = 0;
        postReload = 1;
        inBlank    = 1;
        blankCnt   = 0;
      end else if (inBlank) begin
        blankCnt++;
        if (!busy) begin
          check(blankCnt == 2 * int'(activePeriod), "R7 blank length", blankCnt,
                2 * int'(activePeriod));
          inBlank = 0;
        end
      end
      if (prevValid) begin
        int d;
        bit up;
        d  = int'(carrier) - prevCarrier;
        up = (d > 0);
        check(d == 1 || d == -1, "R1 carrier step", d, 1);
        if (prevUp && !up)
          check(prevCarrier == int'(activePeriod), "R1 carrier peak", prevCarrier,
                activePeriod);
        prevUp = up;
      end
      for (int i = 0; i < 3; i++) begin
        bit expG;
        expG = !busy && (expDuty[i] > carrier);
        check(gate[i] == expG, busy ? "R5 gate while busy" : "R2 R9 gate compare",
              gate[i], expG);
      end
      if (updStb) begin
        check(carrier == '0, "R3 strobe at valley", carrier, 0);
        if (sawFirst)
          check(vcount == (postReload ? DIV : DIV - 1), "R3 strobe spacing", vcount,
                postReload ? DIV : DIV - 1);
        vcount     = 0;
        postReload = 0;
        sawFirst   = 1;
        pendLoad   = 1;
        pendVal[0] = dutyU; pendVal[1] = dutyV; pendVal[2] = dutyW;
      end else if (carrier == '0) begin
        vcount++;
      end
      prevCarrier = int'(carrier);
      prevValid   = 1;
    end
  end

  // random duty driver, drives just after the rising edge
  always @(posedge clk) begin
    if (randDuty) begin
      #1;
      dutyU = W'($urandom_range(int'(activePeriod)));
      dutyV = W'($urandom_range(int'(activePeriod)));
      dutyW = W'($urandom_range(int'(activePeriod)));
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitBusy(input bit level, input string tag);
    int n;
    n = 0;
    while (busy != level && n < 8 * DW + 16 * P) begin
      @(negedge clk);
      n++;
    end
    check(busy == level, tag, busy, level);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int unsigned seedDummy;
    int lat;
    seedDummy = $urandom(32'd20240611);
    rstN = 1'b0;
    freqReq = 2'd0;
    dutyU = W'(2); dutyV = W'(4); dutyW = W'(6);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(carrier == '0, "R10 reset carrier", carrier, 0);
    check(gate == 3'b000, "R10 reset gates", gate, 0);
    check(busy == 1'b0, "R10 reset busy", busy, 0);
    check(cfgStb == 1'b0, "R10 reset cfgStb", cfgStb, 0);
    check(activeMode == 2'd0, "R10 reset mode", activeMode, 0);
    check(activePeriod == W'(P), "R10 reset period", activePeriod, P);
    @(posedge clk); #1 rstN = 1'b1; monOn = 1;

    waitCycles(8 * P);

    // requests that flip faster than the dwell time
    guardOn = 1; busySeen = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1 freqReq = (k % 2) ? 2'd1 : 2'd2;
      waitCycles(DW - 4);
    end
    @(posedge clk); #1 freqReq = 2'd0;
    waitCycles(4);
    check(busySeen == 0, "R4 short requests rejected", busySeen, 0);

    // hold code never starts a change
    busySeen = 0;
    @(posedge clk); #1 freqReq = 2'd3;
    waitCycles(3 * DW);
    @(posedge clk); #1 freqReq = 2'd0;
    waitCycles(DW + 4);
    check(busySeen == 0, "R4 hold code and same rate ignored", busySeen, 0);
    guardOn = 0;

    // accepted change to the slowest rate, with a competing request while busy
    checkTarget = 1; expTarget = 2'd2;
    @(posedge clk); #1 freqReq = 2'd2;
    lat = 0;
    while (!busy && lat < 4 * DW) begin
      @(negedge clk);
      lat++;
    end
    check(lat >= DW + 1 && lat <= DW + 3, "R4 dwell latency", lat, DW + 2);
    check(gate == 3'b000, "R5 gates off on accept", gate, 0);
    @(posedge clk); #1 freqReq = 2'd1;
    waitBusy(1'b0, "R7 sequence completes");
    check(activeMode == 2'd2, "R8 request during busy ignored", activeMode, 2);
    check(activePeriod == W'(4 * P), "R1 slow period", activePeriod, 4 * P);

    // the request left at 1 is now accepted: speed-up with right shift
    expTarget = 2'd1;
    waitBusy(1'b1, "R4 later request accepted");
    waitBusy(1'b0, "R7 second sequence completes");
    check(activeMode == 2'd1, "R9 mid rate active", activeMode, 1);
    check(activePeriod == W'(2 * P), "R6 mid period", activePeriod, 2 * P);
    waitCycles(8 * P * (DIV + 1));

    // randomized requests and duties
    checkTarget = 0; randDuty = 1;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1 freqReq = 2'($urandom_range(3));
      waitCycles(int'($urandom_range(3 * DW, 1)));
    end
    @(posedge clk); #1 freqReq = 2'd3;
    waitBusy(1'b0, "R7 final idle");
    waitCycles(16 * P);
    finishRun();
  end

endmodule